// File: doc/BRIEF.md
# Multi-Lane Serial Transmitter with Frame-Locked Flag Outputs

This block sends parallel words out as serial bit streams on up to three data lanes. The lanes share one bit-clock enable and one frame sync. Software uses a small write-only register bus. It loads a holding register for each lane and writes a 24-bit control word. That word chooses the active lanes, enables the transmit interrupt and carries two general-purpose output flag bits.

The flag bits are staged. A software write lands in the control word only. The two flag pins copy the staged values on the clock edge that starts a frame, which is the edge where the lane-0 word moves from its holding register into its shift register. Flag changes therefore line up with the data words, whatever the time of the software write.

Each frame is `WORD_W` bit periods long. On the first bit every enabled lane loads its shift register and starts sending, MSB first. A per-lane empty flag reports that the holding register has been consumed. A sticky underrun bit reports that a frame started before new data arrived. The interrupt request follows lane-0 empty.

Top module: `sertx_flags`

## Requirements
- R1: After the asynchronous reset, the control word, flag pins, serial outputs, frame sync, underrun bits and interrupt are all 0, and every lane's empty flag is 1.
- R2: A pulse on `sw_rst` clears all 24 control bits at the next clock edge. The flag pins keep their values until the next frame start.
- R3: Bus map: address 0 is the control word, address 1 clears underrun bits (write 1 to bit i), and addresses 2, 3 and 4 are the holding registers of lanes 0, 1 and 2. In the control word, the staged flags are bit 0 (pin 0) and bit 1 (pin 1). Lane 0 is enabled by bit 16, lane 1 by bit 15 and lane 2 by bit 14. Bit 18 enables the interrupt. `ctrl_out` returns the stored word.
- R4: A frame is `WORD_W` cycles with `bit_en` high, counted from reset. On the first of them, `fsync_out` goes high for one bit period. Each enabled lane then loads its shift register and drives its MSB on `sdo`, and each later `bit_en` cycle moves to the next lower bit.
- R5: The flag pins take the staged flag values at the frame-start edge only. A control write never changes the pins at its own edge. A write that coincides with a frame start is seen at the following frame start.
- R6: The flag pins update at every frame start, whether or not any lane is enabled.
- R7: A frame start sets the empty flag of each enabled lane, and a holding write clears it. If both happen in the same cycle, the lane sends the old word and its empty flag ends up 0.
- R8: A disabled lane drives `sdo` low, and a frame start leaves its empty and underrun bits unchanged.
- R9: A frame start on an enabled lane whose holding register is empty resends the last word written and sets that lane's sticky underrun bit. An underrun set in the same cycle as a clear wins.
- R10: `tx_irq` is 1 exactly when lane 0 is empty, the interrupt enable (bit 18) is set and lane 0 is enabled (bit 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous clear of the control word |
| bit_en | input | 1 | One-cycle bit-clock enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 24 | Register write data |
| ctrl_out | output | 24 | Stored control word |
| flag_out | output | 2 | Frame-synchronised flag pins |
| fsync_out | output | 1 | Frame sync, high during the first bit |
| sdo | output | 3 | Serial data, one bit per lane |
| tx_empty | output | 3 | Per-lane holding-register empty flags |
| underrun | output | 3 | Sticky per-lane underrun bits |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The delicate collisions are a frame start that falls in the same cycle as a bus write: a holding write, a control write carrying new flags, or an underrun-clear write. The bench drives each of these on the exact frame-start cycle. It then judges the result on the ports: which word appears on `sdo`, whether the flag pins kept their old values until the following frame, and the resulting empty and underrun state. The flag values are also swept over all four combinations with every lane off, which shows that the pin updates follow frame timing alone.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CTRL_W   = 24;
  localparam int LANES    = 3;
  localparam int ADDR_W   = 3;
  localparam int FLAG_W   = 2;
  localparam int B_FLAG0  = 0;
  localparam int B_TIE    = 18;
  localparam int B_TE_TOP = 16;   // lane 0 enable; lane i uses B_TE_TOP - i
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_UCLR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_LANE0 = 3'd2;

  function automatic int te_pos(input int lane);
    return B_TE_TOP - lane;
  endfunction
endpackage

// File: rtl/sertx_frame.sv
module sertx_frame #(
  parameter int WORD_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  output logic frame_start,
  output logic fsync
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fsync_q, fsync_d;

  assign frame_start = bit_en && (cnt_q == '0);
  assign fsync       = fsync_q;

  always_comb begin
    cnt_d   = cnt_q;
    fsync_d = fsync_q;
    if (bit_en) begin
      cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      fsync_d = (cnt_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fsync_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fsync_q <= fsync_d;
    end
  end

  // R4: the sync pulse lasts one bit period
  p_fsync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync_q && bit_en) |=> !fsync_q);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              frame_start,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [FLAG_W-1:0] flag_pins
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [FLAG_W-1:0] pins_q, pins_d;

  assign flag_pins = pins_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (sw_rst)       ctrl_d = '0;
    else if (wr_ctrl) ctrl_d = wdata;
  end

  always_comb begin
    pins_d = pins_q;
    if (frame_start) pins_d = ctrl_q[B_FLAG0 +: FLAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pins_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      pins_q <= pins_d;
    end
  end

  // R5: pins hold between frame starts
  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pins_q));
  // R5: pins take the staged value held before the load edge
  p_pins_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pins_q == $past(ctrl_q[B_FLAG0 +: FLAG_W])));
  // R2: software clear empties the control word
  p_swrst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctrl_q == '0));
endmodule

// File: rtl/sertx_lane.sv
module sertx_lane #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              frame_start,
  input  logic              lane_en,
  input  logic              wr_hold,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr_urun,
  output logic              sdo,
  output logic              empty,
  output logic              urun
);
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic              empty_q, empty_d;
  logic              urun_q, urun_d;
  logic              load;

  assign load  = frame_start && lane_en;
  assign sdo   = lane_en && shift_q[WORD_W-1];
  assign empty = empty_q;
  assign urun  = urun_q;

  always_comb begin
    hold_d = hold_q;
    if (wr_hold) hold_d = wdata;
  end

  always_comb begin
    shift_d = shift_q;
    if (load)        shift_d = hold_q;
    else if (bit_en) shift_d = shift_q << 1;
  end

  always_comb begin
    empty_d = empty_q;
    if (wr_hold)   empty_d = 1'b0;
    else if (load) empty_d = 1'b1;
  end

  always_comb begin
    urun_d = urun_q;
    if (load && empty_q) urun_d = 1'b1;
    else if (clr_urun)   urun_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      empty_q <= 1'b1;
      urun_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      shift_q <= shift_d;
      empty_q <= empty_d;
      urun_q  <= urun_d;
    end
  end

  // R7: a holding write always leaves the lane full
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |=> !empty_q);
  // R7: an enabled frame start without a write empties the lane
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && lane_en && !wr_hold) |=> empty_q);
  // R8: a disabled lane keeps its empty flag
  p_off_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_en && !wr_hold) |=> $stable(empty_q));
  // R9: underrun rises only at an enabled frame start on an empty lane
  p_urun_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(urun_q) |-> $past(frame_start && lane_en && empty_q));
endmodule

// File: rtl/sertx_flags.sv
module sertx_flags
  import sertx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              bit_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [FLAG_W-1:0] flag_out,
  output logic              fsync_out,
  output logic [LANES-1:0]  sdo,
  output logic [LANES-1:0]  tx_empty,
  output logic [LANES-1:0]  underrun,
  output logic              tx_irq
);
  logic             frame_start;
  logic             wr_ctrl;
  logic [LANES-1:0] lane_en, wr_hold, clr_urun;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign clr_urun = (bus_we && (bus_addr == A_UCLR)) ? bus_wdata[LANES-1:0] : '0;

  sertx_frame #(.WORD_W(WORD_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .fsync       (fsync_out)
  );

  sertx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .wr_ctrl     (wr_ctrl),
    .wdata       (bus_wdata),
    .frame_start (frame_start),
    .ctrl_q      (ctrl_out),
    .flag_pins   (flag_out)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = ctrl_out[te_pos(i)];
    assign wr_hold[i] = bus_we && (bus_addr == A_LANE0 + ADDR_W'(i));

    sertx_lane #(.WORD_W(WORD_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .frame_start (frame_start),
      .lane_en     (lane_en[i]),
      .wr_hold     (wr_hold[i]),
      .wdata       (bus_wdata[WORD_W-1:0]),
      .clr_urun    (clr_urun[i]),
      .sdo         (sdo[i]),
      .empty       (tx_empty[i]),
      .urun        (underrun[i])
    );
  end

  assign tx_irq = tx_empty[0] && ctrl_out[B_TIE] && lane_en[0];

  // R10: the request clears one edge after a lane-0 holding write
  p_irq_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold[0] |=> !tx_irq);
endmodule

// File: tb/tb_sertx_flags.sv
module tb_sertx_flags;
  logic        clk = 1'b0;
  logic        rst_n, sw_rst, bit_en, bus_we;
  logic [2:0]  bus_addr;
  logic [23:0] bus_wdata;
  logic [23:0] ctrl_out;
  logic [1:0]  flag_out;
  logic        fsync_out, tx_irq;
  logic [2:0]  sdo, tx_empty, underrun;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  localparam logic [23:0] TE0 = 24'h1 << 16;
  localparam logic [23:0] TE1 = 24'h1 << 15;
  localparam logic [23:0] TE2 = 24'h1 << 14;
  localparam logic [23:0] TIE = 24'h1 << 18;

  always #2 clk = ~clk;

  sertx_flags dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bit_en(bit_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ctrl_out(ctrl_out), .flag_out(flag_out), .fsync_out(fsync_out),
    .sdo(sdo), .tx_empty(tx_empty), .underrun(underrun), .tx_irq(tx_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic be, input logic we, input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    bit_en = be; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bit_en = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [23:0] word(input int k, input int lane);
    return 24'h5A3C96 ^ (24'(k) * 24'h111111) ^ (24'(lane) * 24'h0F0F0F);
  endfunction

  // one full frame; optional bus write on the frame-start cycle
  task automatic frame(input logic [23:0] w0, input logic [23:0] w1, input logic [23:0] w2,
                       input logic [2:0] on, input logic [1:0] exp_flags,
                       input logic fwe, input logic [2:0] fa, input logic [23:0] fd,
                       input string tag);
    int bad = 0;
    for (int j = 0; j < 24; j++) begin
      if (j == 0) tick(1'b1, fwe, fa, fd);
      else        tick(1'b1, 1'b0, 3'd0, 24'd0);
      if (j == 0) begin
        check({"R4 fsync high ", tag}, fsync_out, 1);
        check({"R5 flags at load ", tag}, flag_out, exp_flags);
      end
      if (j == 1) check({"R4 fsync low ", tag}, fsync_out, 0);
      if (sdo !== {on[2] & w2[23-j], on[1] & w1[23-j], on[0] & w0[23-j]}) bad++;
    end
    check({"R4 serial bits ", tag}, bad, 0);
  endtask

  initial begin
    #(4 * 200000);
    $display("FAIL watchdog: actual=timeout expected=finish");
    errs++;
    if (!done) $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    logic [1:0] pins;
    rst_n = 1'b0; sw_rst = 1'b0; bit_en = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 ctrl", ctrl_out, 0);
    check("R1 flags", flag_out, 0);
    check("R1 empty", tx_empty, 3'b111);
    check("R1 underrun", underrun, 0);
    check("R1 sdo/fsync/irq", {sdo, fsync_out, tx_irq}, 0);

    // R6/R5 sweep of flags with no lane enabled
    pins = 2'b00;
    for (int v = 0; v < 4; v++) begin
      tick(1'b0, 1'b1, 3'd0, 24'(v));
      check("R3 ctrl readback", ctrl_out, v);
      check("R5 no change at write edge", flag_out, pins);
      frame(0, 0, 0, 3'b000, 2'(v), 1'b0, 3'd0, 0, "R6 sweep");
      pins = 2'(v);
      check("R8 idle empty", tx_empty, 3'b111);
      check("R8 idle underrun", underrun, 0);
    end

    // R2 software reset, R10 interrupt
    tick(1'b0, 1'b1, 3'd0, 24'hFFFFFF);
    check("R10 irq set", tx_irq, 1);
    @(negedge clk) sw_rst = 1'b1;
    @(posedge clk); #1; sw_rst = 1'b0;
    check("R2 ctrl cleared", ctrl_out, 0);
    check("R2 pins kept", flag_out, 2'b11);
    check("R10 irq after clear", tx_irq, 0);

    // three lanes, normal transfer
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 3'(2 + i), word(0, i));
    check("R7 written not empty", tx_empty, 0);
    tick(1'b0, 1'b1, 3'd0, TE0 | TE1 | TE2 | TIE | 24'h1);
    check("R10 irq while full", tx_irq, 0);
    frame(word(0,0), word(0,1), word(0,2), 3'b111, 2'b01, 1'b0, 3'd0, 0, "R4 three lanes");
    check("R7 all empty", tx_empty, 3'b111);
    check("R9 no underrun", underrun, 0);
    check("R10 irq on empty", tx_irq, 1);

    // R9 underrun resend and clear
    frame(word(0,0), word(0,1), word(0,2), 3'b111, 2'b01, 1'b0, 3'd0, 0, "R9 resend");
    check("R9 underrun set", underrun, 3'b111);
    tick(1'b0, 1'b1, 3'd1, 24'h2);
    check("R9 clear lane1", underrun, 3'b101);
    tick(1'b0, 1'b1, 3'd1, 24'h7);
    check("R9 clear all", underrun, 0);

    // R8 lane 1 disabled
    tick(1'b0, 1'b1, 3'd0, TE0 | TE2);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1, 3'(2 + i), word(1, i));
    frame(word(1,0), word(1,1), word(1,2), 3'b101, 2'b00, 1'b0, 3'd0, 0, "R8 lane off");
    check("R8 off lane keeps empty", tx_empty, 3'b101);
    check("R8 off lane no underrun", underrun, 0);
    check("R10 irq needs TIE", tx_irq, 0);

    // R7/R5/R9 collisions with the frame start
    tick(1'b0, 1'b1, 3'd0, TE0 | TIE | 24'h2);
    tick(1'b0, 1'b1, 3'd2, word(2, 0));
    frame(word(2,0), 0, 0, 3'b001, 2'b10, 1'b1, 3'd2, word(3,0), "R7 write at load");
    check("R7 write wins empty", tx_empty[0], 0);
    check("R9 no underrun on collide", underrun[0], 0);
    frame(word(3,0), 0, 0, 3'b001, 2'b10, 1'b1, 3'd0, TE0 | TIE | 24'h1, "R5 ctrl at load");
    check("R5 staged kept", ctrl_out[1:0], 2'b01);
    frame(word(3,0), 0, 0, 3'b001, 2'b01, 1'b1, 3'd1, 24'h1, "R9 clear at load");
    check("R9 set wins clear", underrun[0], 1);

    // R10 gating by lane-0 enable
    tick(1'b0, 1'b1, 3'd0, TIE);
    check("R10 gated by TE0", tx_irq, 0);
    tick(1'b0, 1'b1, 3'd0, TIE | TE0);
    check("R10 enabled", tx_irq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule